// File: doc/BRIEF.md
# Timed Memory Cycle Controller

This controller runs one claimed bus cycle at a time against a slow memory or I/O device on a 60x-style processor bus. The bus master supplies a two-bit region code, an active-low claim strobe and an active-low write strobe. The controller accepts a claim while it is idle and stores the region and direction. It drives the matching active-low chip select, and the output enable only when the cycle is a read. It then gives the address acknowledge and the transfer acknowledge, and drops every strobe.

The timed regions are the two I/O regions and flash. Each has a wait constant that is set as a parameter. The constant is the number of clocks the device needs minus three, because entry, acknowledge and exit each take one fixed clock. The SRAM region never uses the timer.

The state machine has five states. IDLE waits for a claim. ENTER is the first strobed clock. WAIT counts the loaded constant down. ACK gives both acknowledges. EXIT releases the strobes. Its transitions are:
- IDLE to ENTER when a claim is seen.
- ENTER to ACK when the region is SRAM or the count is zero. ENTER to WAIT otherwise.
- WAIT to ACK when the last wait clock is reached.
- ACK to EXIT, always.
- EXIT to IDLE, always.

Top module: `mem_cycle_ctrl`

## Requirements
- R1: A synchronous reset (rst high) puts the controller in IDLE. While it is IDLE, every active-low output is high.
- R2: A chip select goes low only during ENTER, WAIT and ACK of a cycle, and only for the stored region. Region 00 selects SRAM, 01 selects I/O 0, 10 selects I/O 1 and 11 selects flash. At most one chip select is low at a time.
- R3: An output enable goes low only together with its region's chip select, and only when write_n was high at acceptance. Both I/O regions drive the single io_oe_n.
- R4: A timed region with wait constant K is busy for K+3 clocks after the accepting edge. The strobes are low for the first K+2 of those clocks. With the default flash constant of 3, a flash cycle takes 6 clocks.
- R5: An SRAM cycle is busy for 3 clocks whatever value the SRAM constant has.
- R6: aack_n and ta_n are both low for exactly one clock per cycle. That clock is the last strobed clock, just before EXIT.
- R7: In EXIT all strobes are high, and the controller is back in IDLE on the next clock.
- R8: A claim seen while the controller is not IDLE has no effect on the cycle in progress.
- R9: If claim_n is held low, a new cycle starts at the first edge after the controller returns to IDLE.
- R10: A timed region whose constant is 0 skips WAIT and is busy for 3 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| region | input | 2 | Region code of the claimed cycle |
| claim_n | input | 1 | Cycle claim, active low |
| write_n | input | 1 | Write strobe, active low |
| sram_cs_n | output | 1 | SRAM chip select |
| sram_oe_n | output | 1 | SRAM output enable |
| io_cs_n | output | 2 | I/O chip selects; bit 0 for region 01, bit 1 for region 10 |
| io_oe_n | output | 1 | Output enable shared by both I/O regions |
| flash_cs_n | output | 1 | Flash chip select |
| flash_oe_n | output | 1 | Flash output enable |
| aack_n | output | 1 | Address acknowledge |
| ta_n | output | 1 | Transfer acknowledge |

## Verification
A claim is accepted at a rising edge, and the strobes go low in the clock that follows that edge. For a timed region the acknowledges come in clock K+2 after acceptance, counting the first strobed clock as clock 1. EXIT follows one clock later, and a held claim is taken at the edge after that. The bench keeps an integer phase count that advances at each rising edge, and it compares every output with the value the phase predicts at each falling edge. A result that arrives one clock early or one clock late is therefore caught in that same clock.

// File: rtl/mcc_pkg.sv
package mcc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ENTER,
        ST_WAIT,
        ST_ACK,
        ST_EXIT
    } mcc_state_t;

    localparam int REGION_W = 2;
    localparam int NUM_REGIONS = 1 << REGION_W;
    localparam logic [REGION_W-1:0] RGN_SRAM  = 2'b00;
    localparam logic [REGION_W-1:0] RGN_IO0   = 2'b01;
    localparam logic [REGION_W-1:0] RGN_IO1   = 2'b10;
    localparam logic [REGION_W-1:0] RGN_FLASH = 2'b11;
endpackage

// File: rtl/mcc_wait_timer.sv
module mcc_wait_timer
    import mcc_pkg::*;
#(
    parameter int CNT_W   = 4,
    parameter int K_SRAM  = 0,
    parameter int K_IO0   = 4,
    parameter int K_IO1   = 1,
    parameter int K_FLASH = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic                dec,
    input  logic                clr,
    input  logic [REGION_W-1:0] sel,
    output logic                is_zero,
    output logic                is_one
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] load_val;

    always_comb begin
        unique case (sel)
            RGN_SRAM:  load_val = CNT_W'(K_SRAM);
            RGN_IO0:   load_val = CNT_W'(K_IO0);
            RGN_IO1:   load_val = CNT_W'(K_IO1);
            default:   load_val = CNT_W'(K_FLASH);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (dec) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign is_zero = (cnt == '0);
    assign is_one  = (cnt == CNT_W'(1));

    // R4
    wait_no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        dec |-> (cnt != '0));

    // R1
    wait_reset_clear_chk: assert property (@(posedge clk)
        rst |=> (cnt == '0));
endmodule

// File: rtl/mcc_strobe_decode.sv
module mcc_strobe_decode
    import mcc_pkg::*;
(
    input  logic                active,
    input  logic                rd,
    input  logic [REGION_W-1:0] sel,
    output logic                sram_cs_n,
    output logic                sram_oe_n,
    output logic [1:0]          io_cs_n,
    output logic                io_oe_n,
    output logic                flash_cs_n,
    output logic                flash_oe_n
);
    logic [NUM_REGIONS-1:0] hit;

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_hit
        assign hit[g] = active && (sel == REGION_W'(g));
    end

    assign sram_cs_n  = ~hit[RGN_SRAM];
    assign io_cs_n[0] = ~hit[RGN_IO0];
    assign io_cs_n[1] = ~hit[RGN_IO1];
    assign flash_cs_n = ~hit[RGN_FLASH];

    assign sram_oe_n  = ~(hit[RGN_SRAM] && rd);
    assign io_oe_n    = ~((hit[RGN_IO0] || hit[RGN_IO1]) && rd);
    assign flash_oe_n = ~(hit[RGN_FLASH] && rd);
endmodule

// File: rtl/mem_cycle_ctrl.sv
module mem_cycle_ctrl
    import mcc_pkg::*;
#(
    parameter int CNT_W   = 4,
    parameter int K_SRAM  = 0,
    parameter int K_IO0   = 4,
    parameter int K_IO1   = 1,
    parameter int K_FLASH = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] region,
    input  logic       claim_n,
    input  logic       write_n,
    output logic       sram_cs_n,
    output logic       sram_oe_n,
    output logic [1:0] io_cs_n,
    output logic       io_oe_n,
    output logic       flash_cs_n,
    output logic       flash_oe_n,
    output logic       aack_n,
    output logic       ta_n
);
    mcc_state_t          state, nxt;
    logic [REGION_W-1:0] lat_region;
    logic                lat_rd;
    logic                accept, t_dec, t_clr, t_zero, t_one;
    logic                strobe_on, ack_on;

    assign accept = (state == ST_IDLE) && !claim_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            lat_region <= RGN_SRAM;
            lat_rd     <= 1'b0;
        end else begin
            state <= nxt;
            if (accept) begin
                lat_region <= region;
                lat_rd     <= write_n;
            end
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (!claim_n) nxt = ST_ENTER;
            ST_ENTER: nxt = ((lat_region == RGN_SRAM) || t_zero) ? ST_ACK : ST_WAIT;
            ST_WAIT:  if (t_one) nxt = ST_ACK;
            ST_ACK:   nxt = ST_EXIT;
            ST_EXIT:  nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        strobe_on = 1'b0;
        ack_on    = 1'b0;
        t_dec     = 1'b0;
        t_clr     = 1'b0;
        unique case (state)
            ST_IDLE:  ;
            ST_ENTER: strobe_on = 1'b1;
            ST_WAIT:  begin strobe_on = 1'b1; t_dec = 1'b1; end
            ST_ACK:   begin strobe_on = 1'b1; ack_on = 1'b1; end
            ST_EXIT:  t_clr = 1'b1;
            default:  ;
        endcase
    end

    assign aack_n = ~ack_on;
    assign ta_n   = ~ack_on;

    mcc_wait_timer #(
        .CNT_W(CNT_W), .K_SRAM(K_SRAM), .K_IO0(K_IO0),
        .K_IO1(K_IO1), .K_FLASH(K_FLASH)
    ) u_timer (
        .clk(clk), .rst(rst), .load(accept), .dec(t_dec), .clr(t_clr),
        .sel(accept ? region : lat_region),
        .is_zero(t_zero), .is_one(t_one)
    );

    mcc_strobe_decode u_decode (
        .active(strobe_on), .rd(lat_rd), .sel(lat_region),
        .sram_cs_n(sram_cs_n), .sram_oe_n(sram_oe_n),
        .io_cs_n(io_cs_n), .io_oe_n(io_oe_n),
        .flash_cs_n(flash_cs_n), .flash_oe_n(flash_oe_n)
    );

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (aack_n && ta_n && sram_cs_n && flash_cs_n && (&io_cs_n)
                 && sram_oe_n && io_oe_n && flash_oe_n));

    // R2
    one_select_chk: assert property (@(posedge clk) disable iff (rst)
        $countones({sram_cs_n, flash_cs_n, io_cs_n}) >= 3);

    // R3
    oe_with_cs_chk: assert property (@(posedge clk) disable iff (rst)
        (!sram_oe_n |-> !sram_cs_n) and (!flash_oe_n |-> !flash_cs_n)
        and (!io_oe_n |-> !(&io_cs_n)));

    // R6
    ack_single_chk: assert property (@(posedge clk) disable iff (rst)
        !ta_n |=> ta_n);

    // R7
    exit_release_chk: assert property (@(posedge clk) disable iff (rst)
        !aack_n |=> (sram_cs_n && flash_cs_n && (&io_cs_n) && (state == ST_EXIT)));

    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE) |=> $stable(lat_region) && $stable(lat_rd));
endmodule

// File: tb/tb_mem_cycle_ctrl.sv
module tb_mem_cycle_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int KS = 9;
    localparam int K0 = 5;
    localparam int K1 = 0;
    localparam int KF = 3;
    localparam int WATCHDOG = 100000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] region = 2'b00;
    logic claim_n = 1'b1;
    logic write_n = 1'b1;
    logic sram_cs_n, sram_oe_n, io_oe_n, flash_cs_n, flash_oe_n, aack_n, ta_n;
    logic [1:0] io_cs_n;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string cur_req = "R1";
    logic started = 1'b0;

    int m_busy = 0;
    int m_phase = 0;
    int m_total = 0;
    int m_region = 0;
    int m_rd = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mem_cycle_ctrl #(.CNT_W(4), .K_SRAM(KS), .K_IO0(K0), .K_IO1(K1), .K_FLASH(KF)) dut (
        .clk(clk), .rst(rst), .region(region), .claim_n(claim_n), .write_n(write_n),
        .sram_cs_n(sram_cs_n), .sram_oe_n(sram_oe_n), .io_cs_n(io_cs_n),
        .io_oe_n(io_oe_n), .flash_cs_n(flash_cs_n), .flash_oe_n(flash_oe_n),
        .aack_n(aack_n), .ta_n(ta_n)
    );

    function automatic int span(input int r);
        case (r)
            0: return 3;
            1: return K0 + 3;
            2: return K1 + 3;
            default: return KF + 3;
        endcase
    endfunction

    always @(posedge clk) begin
        started <= 1'b1;
        if (rst) begin
            m_busy <= 0;
        end else if (m_busy != 0) begin
            if (m_phase == m_total - 1) m_busy <= 0;
            else m_phase <= m_phase + 1;
        end else if (!claim_n) begin
            m_busy <= 1;
            m_phase <= 0;
            m_region <= int'(region);
            m_rd <= int'(write_n);
            m_total <= span(int'(region));
        end
    end

    task automatic chk(input logic act, input logic exp, input string nm);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b t=%0t", cur_req, nm, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (started) begin
            automatic logic act = (m_busy != 0) && (m_phase <= m_total - 2);
            automatic logic ack = (m_busy != 0) && (m_phase == m_total - 2);
            automatic logic rd = (m_rd != 0);
            chk(sram_cs_n,  !(act && m_region == 0), "sram_cs_n");
            chk(io_cs_n[0], !(act && m_region == 1), "io_cs_n0");
            chk(io_cs_n[1], !(act && m_region == 2), "io_cs_n1");
            chk(flash_cs_n, !(act && m_region == 3), "flash_cs_n");
            chk(sram_oe_n,  !(act && rd && m_region == 0), "sram_oe_n");
            chk(io_oe_n,    !(act && rd && (m_region == 1 || m_region == 2)), "io_oe_n");
            chk(flash_oe_n, !(act && rd && m_region == 3), "flash_oe_n");
            chk(aack_n, !ack, "aack_n");
            chk(ta_n,   !ack, "ta_n");
        end
        cycles++;
        if (cycles > WATCHDOG) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic wait_idle();
        @(negedge clk);
        while (m_busy != 0) @(negedge clk);
    endtask

    task automatic issue(input logic [1:0] r, input logic w);
        wait_idle();
        region = r;
        write_n = w;
        claim_n = 1'b0;
        @(negedge clk);
        claim_n = 1'b1;
        region = ~r;
    endtask

    initial begin
        cur_req = "R1";
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        cur_req = "R2";
        issue(2'b01, 1'b0);
        issue(2'b10, 1'b0);
        cur_req = "R3";
        issue(2'b01, 1'b1);
        issue(2'b00, 1'b1);
        issue(2'b00, 1'b0);
        cur_req = "R4";
        issue(2'b11, 1'b1);
        issue(2'b11, 1'b0);
        cur_req = "R5";
        issue(2'b00, 1'b1);
        cur_req = "R10";
        issue(2'b10, 1'b1);
        cur_req = "R6";
        issue(2'b01, 1'b1);
        cur_req = "R7";
        issue(2'b11, 1'b1);

        cur_req = "R8";
        issue(2'b01, 1'b1);
        region = 2'b11;
        write_n = 1'b0;
        claim_n = 1'b0;
        @(negedge clk);
        claim_n = 1'b1;
        wait_idle();

        cur_req = "R9";
        region = 2'b11;
        write_n = 1'b1;
        claim_n = 1'b0;
        repeat (20) @(negedge clk);
        region = 2'b00;
        repeat (8) @(negedge clk);
        claim_n = 1'b1;
        wait_idle();

        cur_req = "R1";
        issue(2'b01, 1'b1);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule